// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Decoder

This block turns the three digital Hall sensor levels of a three-phase brushless motor into switch selections for a six-step bridge. For each valid sensor code it turns on one high-side switch and one low-side switch, on two different phases. A direction input chooses forward or reverse rotation. Reverse rotation reuses the forward table, looked up with the bitwise complement of the sensor code.

The sensor inputs are asynchronous. They pass through a synchronizer before they are decoded, and every output is registered. A tachometer output is the XOR of the three synchronized sensor bits, so it toggles on every sensor edge. The decoder treats the sensor codes 000 and 111 as faults and drives no switch for them. An enable input blanks every output when it is low. A brake request overrides everything else: it turns on all low-side switches so that the windings are shorted, and it keeps all high-side switches off.

PWM modulation of the low side and the analog sensor comparators live outside this block.

Top module: `hall_commutator`

## Requirements
- R1: The sensor code is written as hall_i[2:0]. Phase vectors use bit 0 = U, bit 1 = V and bit 2 = W. With dir_fwd_i = 1, en_i = 1 and brake_i = 0, the codes select these switches: 101 gives high V and low U; 100 gives high W and low U; 110 gives high W and low V; 010 gives high U and low V; 011 gives high U and low W; 001 gives high V and low W.
- R2: With dir_fwd_i = 0, the switch pair is the one that R1 gives for the bitwise complement of the sensor code.
- R3: The sensor codes 000 and 111 drive every high-side and low-side output to 0, in both directions.
- R4: tach_o equals the XOR of the three sensor bits. It is 1 for codes 100, 010 and 001, and 0 for codes 101, 110 and 011. It does not depend on en_i, brake_i or dir_fwd_i.
- R5: While brake_i = 1, lo_en_o = 111 and hi_en_o = 000, whatever the values of en_i, dir_fwd_i and the sensor code.
- R6: While en_i = 0 and brake_i = 0, hi_en_o and lo_en_o are both 000.
- R7: A change on hall_i shows at the outputs after the third rising clock edge. A change on en_i, brake_i or dir_fwd_i shows after the first rising edge.
- R8: A high-side output and a low-side output of the same phase are never both 1. At most one high-side output is 1. At most one low-side output is 1 unless the brake is applied.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Asynchronous Hall sensor levels |
| dir_fwd_i | input | 1 | 1 = forward rotation, 0 = reverse |
| en_i | input | 1 | Drive enable |
| brake_i | input | 1 | Short-brake request |
| hi_en_o | output | 3 | High-side switch enables (U, V, W) |
| lo_en_o | output | 3 | Low-side switch enables (U, V, W) |
| tach_o | output | 1 | Tachometer, XOR of the synchronized sensors |

## Verification
The hardest situations to create are those where the sensor path and the control path disagree in time. These are a sensor edge that is still inside the synchronizer while the brake or the enable changes, and the invalid sensor codes seen while the brake is applied. The stimulus holds each sensor code while the control inputs switch, so the one-cycle control path and the three-cycle sensor path are both observed. The stimulus also steps the sensor code and samples the outputs after the second and after the third rising edge, which pins the latency exactly. Both fault codes are applied in both directions and again under brake, to confirm that the brake still takes priority.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;

    localparam int NUM_PH   = 3;
    localparam int CODE_W   = NUM_PH;

    typedef logic [NUM_PH-1:0] phase_vec_t;

    localparam phase_vec_t PH_NONE = '0;
    localparam phase_vec_t PH_U    = phase_vec_t'(1 << 0);
    localparam phase_vec_t PH_V    = phase_vec_t'(1 << 1);
    localparam phase_vec_t PH_W    = phase_vec_t'(1 << 2);
    localparam phase_vec_t PH_ALL  = '1;

    // switch pair selected by one commutation step
    typedef struct packed {
        phase_vec_t hi;
        phase_vec_t lo;
        logic       valid;
    } step_t;

    // registered output bundle
    typedef struct packed {
        phase_vec_t hi;
        phase_vec_t lo;
        logic       tach;
    } drive_t;

endpackage

// File: rtl/hall_sync.sv
module hall_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;

        if (g == 0) begin : g_first
            always_comb stage_d = async_i;
        end else begin : g_next
            always_comb stage_d = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/comm_table.sv
module comm_table
    import hall_comm_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              dir_fwd_i,
    output step_t             step_o
);

    logic [CODE_W-1:0] index;

    // reverse rotation walks the same table with the complemented code
    always_comb index = dir_fwd_i ? code_i : ~code_i;

    always_comb begin
        step_o = '{hi: PH_NONE, lo: PH_NONE, valid: 1'b0};
        unique case (index)
            3'b101: step_o = '{hi: PH_V, lo: PH_U, valid: 1'b1};
            3'b100: step_o = '{hi: PH_W, lo: PH_U, valid: 1'b1};
            3'b110: step_o = '{hi: PH_W, lo: PH_V, valid: 1'b1};
            3'b010: step_o = '{hi: PH_U, lo: PH_V, valid: 1'b1};
            3'b011: step_o = '{hi: PH_U, lo: PH_W, valid: 1'b1};
            3'b001: step_o = '{hi: PH_V, lo: PH_W, valid: 1'b1};
            default: step_o = '{hi: PH_NONE, lo: PH_NONE, valid: 1'b0};
        endcase
    end

endmodule

// File: rtl/drive_select.sv
module drive_select
    import hall_comm_pkg::*;
(
    input  step_t      step_i,
    input  logic       en_i,
    input  logic       brake_i,
    output phase_vec_t hi_o,
    output phase_vec_t lo_o
);

    // brake outranks enable, enable outranks the table
    always_comb begin
        if (brake_i) begin
            hi_o = PH_NONE;
            lo_o = PH_ALL;
        end else if (!en_i || !step_i.valid) begin
            hi_o = PH_NONE;
            lo_o = PH_NONE;
        end else begin
            hi_o = step_i.hi;
            lo_o = step_i.lo;
        end
    end

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_fwd_i,
    input  logic       en_i,
    input  logic       brake_i,
    output logic [2:0] hi_en_o,
    output logic [2:0] lo_en_o,
    output logic       tach_o
);

    logic [CODE_W-1:0] hall_sync_w;
    step_t             step_w;
    phase_vec_t        hi_sel_w;
    phase_vec_t        lo_sel_w;
    drive_t            drv_d;
    drive_t            drv_q;

    hall_sync #(
        .WIDTH  (CODE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hall_i),
        .sync_o  (hall_sync_w)
    );

    comm_table u_table (
        .code_i    (hall_sync_w),
        .dir_fwd_i (dir_fwd_i),
        .step_o    (step_w)
    );

    drive_select u_sel (
        .step_i  (step_w),
        .en_i    (en_i),
        .brake_i (brake_i),
        .hi_o    (hi_sel_w),
        .lo_o    (lo_sel_w)
    );

    always_comb begin
        drv_d      = drv_q;
        drv_d.hi   = hi_sel_w;
        drv_d.lo   = lo_sel_w;
        drv_d.tach = ^hall_sync_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign hi_en_o = drv_q.hi;
    assign lo_en_o = drv_q.lo;
    assign tach_o  = drv_q.tach;

endmodule

// File: rtl/hall_commutator_checker.sv
module hall_commutator_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_i,
    input logic       en_i,
    input logic       brake_i,
    input logic [2:0] hi_en_o,
    input logic [2:0] lo_en_o,
    input logic       tach_o
);

    // counts edges since reset so that $past(...,3) never reaches back into reset
    logic [2:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end
    logic settled;
    assign settled = (age_q >= 3'd4);

    // R8
    a_r8_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en_o & lo_en_o) == 3'b000);

    // R8
    a_r8_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hi_en_o));

    // R5
    a_r5_brake_shorts_low: assert property (@(posedge clk) disable iff (!rst_n)
        brake_i |=> (lo_en_o == 3'b111 && hi_en_o == 3'b000));

    // R6
    a_r6_disable_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !brake_i) |=> (lo_en_o == 3'b000 && hi_en_o == 3'b000));

    // R8
    a_r8_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_i |=> $onehot0(lo_en_o));

    // R4
    a_r4_tach_xor: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> (tach_o == ^$past(hall_i, 3)));

    // R3
    a_r3_bad_code_off: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !$past(brake_i) &&
         ($past(hall_i, 3) == 3'b000 || $past(hall_i, 3) == 3'b111))
        |-> (hi_en_o == 3'b000 && lo_en_o == 3'b000));

endmodule

bind hall_commutator hall_commutator_checker u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .hall_i  (hall_i),
    .en_i    (en_i),
    .brake_i (brake_i),
    .hi_en_o (hi_en_o),
    .lo_en_o (lo_en_o),
    .tach_o  (tach_o)
);

// File: tb/hall_commutator_test.sv
`timescale 1ns/1ps
module hall_commutator_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_i = 3'b000;
    logic       dir_fwd_i = 1'b1;
    logic       en_i = 1'b0;
    logic       brake_i = 1'b0;
    logic [2:0] hi_en_o;
    logic [2:0] lo_en_o;
    logic       tach_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hall_commutator uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hall_i    (hall_i),
        .dir_fwd_i (dir_fwd_i),
        .en_i      (en_i),
        .brake_i   (brake_i),
        .hi_en_o   (hi_en_o),
        .lo_en_o   (lo_en_o),
        .tach_o    (tach_o)
    );

    // expected {hi, lo} written from the R1 table
    function automatic logic [5:0] fwd_pair(input logic [2:0] c);
        case (c)
            3'b101: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b110: return {3'b100, 3'b010};
            3'b010: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b001: return {3'b010, 3'b100};
            default: return 6'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual hi/lo/tach=%b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] c, input logic fwd, input logic en, input logic brk);
        @(negedge clk);
        hall_i = c; dir_fwd_i = fwd; en_i = en; brake_i = brk;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R9", {hi_en_o, lo_en_o, tach_o}, 7'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_forward;
        for (int c = 1; c < 7; c++) begin
            apply(3'(c), 1'b1, 1'b1, 1'b0);
            check("R1", {hi_en_o, lo_en_o, tach_o}, {fwd_pair(3'(c)), ^3'(c)});
        end
    endtask

    task automatic t_reverse;
        for (int c = 1; c < 7; c++) begin
            apply(3'(c), 1'b0, 1'b1, 1'b0);
            check("R2", {hi_en_o, lo_en_o, tach_o}, {fwd_pair(~3'(c)), ^3'(c)});
        end
    endtask

    task automatic t_invalid;
        for (int d = 0; d < 2; d++) begin
            apply(3'b000, 1'(d), 1'b1, 1'b0);
            check("R3", {hi_en_o, lo_en_o, tach_o}, 7'b0);
            apply(3'b111, 1'(d), 1'b1, 1'b0);
            check("R3", {hi_en_o, lo_en_o, tach_o}, {6'b0, 1'b1});
        end
    endtask

    task automatic t_tach;
        for (int c = 0; c < 8; c++) begin
            apply(3'(c), 1'b0, 1'b0, 1'b1);
            check("R4", {6'b000111, tach_o}, {6'b000111, ^3'(c)});
        end
    endtask

    task automatic t_brake;
        apply(3'b101, 1'b1, 1'b1, 1'b1);
        check("R5", {hi_en_o, lo_en_o, tach_o}, {6'b000111, 1'b0});
        apply(3'b100, 1'b0, 1'b0, 1'b1);
        check("R5", {hi_en_o, lo_en_o, tach_o}, {6'b000111, 1'b1});
        apply(3'b111, 1'b1, 1'b1, 1'b1);
        check("R5", {hi_en_o, lo_en_o, tach_o}, {6'b000111, 1'b1});
        // release: control path takes one edge
        @(negedge clk); brake_i = 1'b0;
        @(negedge clk);
        check("R7", {hi_en_o, lo_en_o, tach_o}, 7'b0000001);
    endtask

    task automatic t_disable;
        apply(3'b011, 1'b1, 1'b1, 1'b0);
        check("R1", {hi_en_o, lo_en_o, tach_o}, {fwd_pair(3'b011), 1'b0});
        @(negedge clk); en_i = 1'b0;
        @(negedge clk);
        check("R6", {hi_en_o, lo_en_o, tach_o}, 7'b0);
        @(negedge clk); en_i = 1'b1;
        @(negedge clk);
        check("R7", {hi_en_o, lo_en_o, tach_o}, {fwd_pair(3'b011), 1'b0});
        @(negedge clk); dir_fwd_i = 1'b0;
        @(negedge clk);
        check("R7", {hi_en_o, lo_en_o, tach_o}, {fwd_pair(3'b100), 1'b0});
    endtask

    task automatic t_latency;
        apply(3'b101, 1'b1, 1'b1, 1'b0);
        @(negedge clk); hall_i = 3'b100;
        repeat (2) @(negedge clk);
        check("R7", {hi_en_o, lo_en_o, tach_o}, {fwd_pair(3'b101), 1'b0});
        @(negedge clk);
        check("R7", {hi_en_o, lo_en_o, tach_o}, {fwd_pair(3'b100), 1'b1});
    endtask

    task automatic t_exclusive;
        for (int c = 0; c < 8; c++) begin
            for (int d = 0; d < 2; d++) begin
                apply(3'(c), 1'(d), 1'b1, 1'b0);
                check("R8", {3'b0, (hi_en_o & lo_en_o), $onehot0(hi_en_o) && $onehot0(lo_en_o)},
                            {3'b0, 3'b000, 1'b1});
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_forward();
        t_reverse();
        t_invalid();
        t_tach();
        t_brake();
        t_disable();
        t_latency();
        t_exclusive();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule